// File: doc/BRIEF.md
# Scan Channel/Gain Queue Sequencer

This block keeps an ordered list of conversion settings for a multiplexed analog input front end. Each setting pairs a channel number with a range code. While an acquisition runs, every conversion strobe moves the block to the next setting and presents that setting, registered, to the multiplexer and gain stage. After the last programmed setting the pointer returns to the start and the block raises a one-cycle end-of-scan strobe.

The host programs the list one byte at a time. It first writes an entry index to an index register and then writes the entry byte, which is stored at that index. A separate register holds the index of the last valid entry and so sets the scan length. A scan of two or more entries must have an even length. In it, every entry whose index is even must hold an even channel, and every entry whose index is odd must hold an odd channel. The block reports any entry that breaks this rule on an error output.

Top module: `scanq_seq`

## Requirements
- R1: After reset, `chan_o`, `range_o` and `unipolar_o` are 0, `eos_o` is 0, `running_o` is 0, every queue entry is 0, the last-index register is 0 and `parity_err_o` is 0.
- R2: A pulse on `idx_wr_i` loads `wdata_i` into the index register. A following pulse on `ent_wr_i` stores `wdata_i` at that index, with the channel in bits 2:0 and the range code in bits 7:4. Bit 3 is ignored. When the entry is presented, it appears as `chan_o` = bits 2:0, `range_o` = bits 7:4 and `unipolar_o` = bit 6.
- R3: A pulse on `arm_i` sets `running_o`. After the same clock edge, the block presents entry 0.
- R4: While the block runs, each `conv_i` pulse advances the pointer by one. After that edge the block presents the new entry.
- R5: A `conv_i` pulse at the last-index entry wraps the pointer to entry 0. `eos_o` is high for exactly the cycle in which entry 0 is presented again. At no other time is `eos_o` high.
- R6: When the last index is 0, every `conv_i` pulse while running keeps entry 0 presented and pulses `eos_o`.
- R7: `parity_err_o` is high exactly when the last index is nonzero and some entry at an index no greater than the last index has a channel whose bit 0 differs from bit 0 of its index. Entries beyond the last index never set it.
- R8: While `running_o` is high, writes to the index register, to queue entries and to the last-index register are ignored.
- R9: A pulse on `stop_i` clears `running_o` and has priority over `arm_i` and `conv_i`. While the block is stopped, `conv_i` leaves the presented entry and `eos_o` unchanged.
- R10: With all 256 entries in use (last index 255), the scan steps through every index and wraps only after index 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Write strobe for the index register |
| ent_wr_i | input | 1 | Write strobe for the entry at the current index |
| last_wr_i | input | 1 | Write strobe for the last-index register |
| wdata_i | input | 8 | Host write byte |
| arm_i | input | 1 | Start acquisition at entry 0 |
| stop_i | input | 1 | Stop acquisition |
| conv_i | input | 1 | Conversion strobe |
| running_o | output | 1 | Acquisition active |
| chan_o | output | 3 | Presented channel |
| range_o | output | 4 | Presented range code |
| unipolar_o | output | 1 | Presented entry selects unipolar range |
| eos_o | output | 1 | End-of-scan strobe |
| parity_err_o | output | 1 | Channel/index parity rule broken |

## Verification
The hardest case to reach from the ports is a write that the block ignores during a run. Nothing shows such a write directly: its effect can only be seen later, through the contents of the queue and the scan length. To reach it, the bench writes a different last index and different entry bytes while a scan is running. It then stops, re-arms and steps through a whole scan. Entry values and `eos_o` timing must match the list as it stood before the ignored writes. For the parity rule, the stimulus places an offending entry first inside and then just beyond the last index, and it also covers the single-entry case.

// File: rtl/scanq_pkg.sv
package scanq_pkg;
  localparam int unsigned CHAN_W  = 3;
  localparam int unsigned RANGE_W = 4;

  typedef struct packed {
    logic [RANGE_W-1:0] range;
    logic [CHAN_W-1:0]  chan;
  } scan_ent_t;

  localparam int unsigned ENT_W = $bits(scan_ent_t);

  // channel in byte bits 2:0, range code in bits 7:4
  function automatic scan_ent_t unpack_byte(input logic [7:0] b);
    scan_ent_t e;
    e.chan  = b[CHAN_W-1:0];
    e.range = b[7:4];
    return e;
  endfunction
endpackage

// File: rtl/scanq_store.sv
module scanq_store
  import scanq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  scan_ent_t        wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output scan_ent_t        rdata_o,
  input  logic [IDX_W-1:0] last_i,
  output logic             mism_o
);
  scan_ent_t        ent_q [DEPTH];
  logic [DEPTH-1:0] mism;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       ent_q[i] <= '0;
      else if (we_i && waddr_i == IDX)   ent_q[i] <= wdata_i;
    end
    assign mism[i] = (ent_q[i].chan[0] != IDX[0]) && (IDX <= last_i);
  end

  assign rdata_o = ent_q[raddr_i];
  assign mism_o  = |mism;
endmodule

// File: rtl/scanq_ptr.sv
module scanq_ptr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic             conv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic             running_o,
  output logic [IDX_W-1:0] next_o,
  output logic             load_o,
  output logic             eos_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             run_q, eos_q, wrap, step;

  assign wrap   = (ptr_q == last_i);
  assign step   = !stop_i && !arm_i && conv_i && run_q;
  assign load_o = !stop_i && (arm_i || (conv_i && run_q));
  assign next_o = (arm_i || wrap) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ptr_q <= '0;
      eos_q <= 1'b0;
    end else begin
      eos_q <= step && wrap;
      if (stop_i) begin
        run_q <= 1'b0;
      end else if (arm_i) begin
        run_q <= 1'b1;
        ptr_q <= '0;
      end else if (step) begin
        ptr_q <= next_o;
      end
    end
  end

  assign running_o = run_q;
  assign eos_o     = eos_q;
endmodule

// File: rtl/scanq_seq.sv
module scanq_seq
  import scanq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               idx_wr_i,
  input  logic               ent_wr_i,
  input  logic               last_wr_i,
  input  logic [7:0]         wdata_i,
  input  logic               arm_i,
  input  logic               stop_i,
  input  logic               conv_i,
  output logic               running_o,
  output logic [CHAN_W-1:0]  chan_o,
  output logic [RANGE_W-1:0] range_o,
  output logic               unipolar_o,
  output logic               eos_o,
  output logic               parity_err_o
);
  logic [IDX_W-1:0] idx_q, last_q, next_idx;
  scan_ent_t        rd_ent, out_q;
  logic             host_en, load, mism;
  logic             unused_rsvd;

  assign unused_rsvd = wdata_i[3];
  assign host_en     = !running_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      last_q <= '0;
      out_q  <= '0;
    end else begin
      if (host_en && idx_wr_i)  idx_q  <= wdata_i[IDX_W-1:0];
      if (host_en && last_wr_i) last_q <= wdata_i[IDX_W-1:0];
      if (load)                 out_q  <= rd_ent;
    end
  end

  scanq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_en && ent_wr_i),
    .waddr_i (idx_q),
    .wdata_i (unpack_byte(wdata_i)),
    .raddr_i (next_idx),
    .rdata_o (rd_ent),
    .last_i  (last_q),
    .mism_o  (mism)
  );

  scanq_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .stop_i    (stop_i),
    .conv_i    (conv_i),
    .last_i    (last_q),
    .running_o (running_o),
    .next_o    (next_idx),
    .load_o    (load),
    .eos_o     (eos_o)
  );

  assign chan_o       = out_q.chan;
  assign range_o      = out_q.range;
  assign unipolar_o   = out_q.range[2];
  assign parity_err_o = (last_q != '0) && mism;
endmodule

// File: rtl/scanq_sva.sv
module scanq_sva #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             stop_i,
  input logic             conv_i,
  input logic             running_o,
  input logic [2:0]       chan_o,
  input logic [3:0]       range_o,
  input logic             eos_o,
  input logic             parity_err_o,
  input logic [IDX_W-1:0] last_q
);
  assert_arm_runs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !stop_i) |=> running_o);

  assert_eos_after_conv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !running_o) |=> !eos_o);

  assert_single_entry_eos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_o && conv_i && !arm_i && !stop_i && last_q == '0) |=> eos_o);

  assert_no_err_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_q == '0) |-> !parity_err_o);

  assert_last_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |=> $stable(last_q));

  assert_stop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !arm_i) |=> ($stable(chan_o) && $stable(range_o)));
endmodule

bind scanq_seq scanq_sva #(.IDX_W(IDX_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .arm_i        (arm_i),
  .stop_i       (stop_i),
  .conv_i       (conv_i),
  .running_o    (running_o),
  .chan_o       (chan_o),
  .range_o      (range_o),
  .eos_o        (eos_o),
  .parity_err_o (parity_err_o),
  .last_q       (last_q)
);

// File: tb/scanq_seq_test.sv
module scanq_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idx_wr = 0, ent_wr = 0, last_wr = 0, arm = 0, stop = 0, conv = 0;
  logic [7:0] wdata = 0;
  logic running, unip, eos, perr;
  logic [2:0] chan;
  logic [3:0] rng;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [7:0] mq [DEPTH];
  int m_last = 0, m_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanq_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_wr_i(idx_wr), .ent_wr_i(ent_wr),
    .last_wr_i(last_wr), .wdata_i(wdata), .arm_i(arm), .stop_i(stop),
    .conv_i(conv), .running_o(running), .chan_o(chan), .range_o(rng),
    .unipolar_o(unip), .eos_o(eos), .parity_err_o(perr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_perr();
    if (m_last == 0) return 0;
    for (int i = 0; i <= m_last; i++)
      if (mq[i][0] != i[0]) return 1;
    return 0;
  endfunction

  task automatic strobe(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic put(int idx, logic [7:0] b);
    wdata = 8'(idx); strobe(idx_wr);
    wdata = b;       strobe(ent_wr);
    if (!running) mq[idx] = b;
  endtask

  task automatic set_last(int l);
    wdata = 8'(l); strobe(last_wr);
    if (!running) m_last = l;
  endtask

  task automatic check_out(string req, bit exp_eos);
    check({req, " chan"}, chan, mq[m_ptr][2:0]);
    check({req, " range"}, rng, mq[m_ptr][7:4]);
    check({req, " unipolar"}, unip, mq[m_ptr][6]);
    check({req, " eos"}, eos, exp_eos);
  endtask

  task automatic do_arm();
    strobe(arm);
    m_ptr = 0;
    check("R3 running", running, 1);
    check_out("R3", 0);
  endtask

  task automatic do_conv(string req);
    bit w;
    strobe(conv);
    w = (m_ptr == m_last);
    m_ptr = w ? 0 : m_ptr + 1;
    check_out(req, w);
  endtask

  function automatic logic [7:0] rnd_byte(int idx, bit legal);
    logic [7:0] b = 8'($urandom);
    if (legal) b[0] = idx[0];
    return b;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) mq[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 running", running, 0);
    check("R1 chan", chan, 0);
    check("R1 range", rng, 0);
    check("R1 eos", eos, 0);
    check("R1 perr", perr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field positions, bit 3 ignored
    put(0, 8'b0101_1010);
    put(1, 8'b1001_0011);
    set_last(1);
    check("R7 legal pair", perr, 0);
    do_arm();
    check("R2 chan bits", chan, 3'b010);
    check("R2 range bits", rng, 4'b0101);
    check("R2 unipolar bit6", unip, 1);
    do_conv("R4 advance");
    do_conv("R5 wrap");
    // R9: stop, conv while stopped holds output and eos
    strobe(stop);
    check("R9 stopped", running, 0);
    strobe(conv);
    check_out("R9 idle conv", 0);
    // R9: stop priority over arm
    stop = 1; arm = 1; @(negedge clk); stop = 0; arm = 0;
    check("R9 stop priority", running, 0);

    // R7: offending entry inside vs beyond last
    put(2, 8'h01);
    put(3, 8'h03);
    check("R7 beyond last", perr, 0);
    set_last(3);
    check("R7 inside last", perr, exp_perr());
    set_last(0);
    check("R7 single entry", perr, 0);

    // R6 single-entry scan
    do_arm();
    for (int k = 0; k < 3; k++) do_conv("R6 single");

    // R8 writes ignored while running
    set_last(5);
    put(0, 8'hF7);
    check("R8 perr unchanged", perr, exp_perr());
    strobe(stop);
    do_arm();
    do_conv("R8 last kept");
    strobe(stop);

    // random scans
    for (int t = 0; t < 40; t++) begin
      int len = 2 * (1 + int'($urandom % 12));
      bit legal = ($urandom % 3) != 0;
      if ($urandom % 8 == 0) len = 1;
      for (int i = 0; i < len; i++) put(i, rnd_byte(i, legal));
      set_last(len - 1);
      check("R7 random", perr, exp_perr());
      do_arm();
      for (int k = 0; k < 2 * len + 1; k++) do_conv("R4 random");
      if (t % 5 == 0) begin
        set_last(($urandom % 4) + 1);
        put(0, 8'($urandom));
        strobe(stop);
        do_arm();
        for (int k = 0; k < len + 1; k++) do_conv("R8 random");
      end
      strobe(stop);
    end

    // R10 full depth
    for (int i = 0; i < DEPTH; i++) put(i, rnd_byte(i, 1));
    set_last(DEPTH - 1);
    check("R10 perr", perr, 0);
    do_arm();
    for (int k = 0; k < DEPTH + 2; k++) do_conv("R10 full");
    strobe(stop);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule